// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a processor with a single instruction. Each instruction is four consecutive memory words that hold four addresses: a first operand (the minuend), a second operand (the subtrahend), a result address and a branch target. The core reads both operands and writes their difference to the result address. It then continues at the branch target when the difference is negative, and at the next instruction otherwise. Code and data share one word-addressed RAM. The core makes one access per clock to that RAM, so each instruction takes seven cycles: four field fetches, two operand reads and one execute cycle.

The program counter, a status word and an accumulator appear at the three lowest addresses. Software therefore jumps by storing a difference into address 0, copies a value by subtracting a word that holds zero, and clears a word by subtracting it from itself. A host fills the memory through a load port while holding the core in its start state. When the host releases the load enable, execution begins at address `START`. The core raises `halt` when it reaches an instruction that branches to itself.

Top module: `sbn_core`

## Requirements
- R1: An instruction at address p takes its first-operand, second-operand, result and target addresses from words p, p+1, p+2 and p+3, in that order. It stores first-operand value minus second-operand value, 32-bit two's complement, to the result address.
- R2: When bit 31 of the difference is set, the next instruction is at the target address. Otherwise the next instruction is at p+4.
- R3: A read of address 0 returns the address of the executing instruction. A read of address 1 returns the status word. A read of address 2 returns the accumulator. A result written to address 2 loads the accumulator.
- R4: A result written to address 0 becomes the next program counter, whatever the sign of the difference.
- R5: Every instruction sets the status word to bit 0 = sign of the difference and bit 1 = difference equals zero, with all other bits zero. A result written to address 1 is discarded.
- R6: A negative difference whose target equals the instruction's own address, with a result address other than 0, completes its write and then raises `halt`. From then on the program counter and memory stay unchanged until `loadEn` is asserted.
- R7: Each instruction takes exactly seven clock cycles. After the first rising edge with `loadEn` low, `halt` rises after edge 7N, where N is the number of instructions executed including the halting one.
- R8: While `loadEn` is high, the core executes nothing, holds the program counter at `START`, lowers `halt`, and writes `loadData` to `loadAddr`. Loads to addresses 0 to 2 leave the program counter, status word and accumulator unchanged.
- R9: `peekData` always shows the word at `loadAddr`, through the same mapping that the core uses for reads.
- R10: Subtracting a word that holds zero copies the first operand to the result. Subtracting a word from itself stores zero.
- R11: After reset, `halt` is low, the program counter is `START`, and the status word and accumulator are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Host load enable; holds the core at its start state |
| loadAddr | input | ADDR_W | Host write and peek address |
| loadData | input | DATA_W | Host write data |
| peekData | output | DATA_W | Mapped word at loadAddr |
| halt | output | 1 | Core stopped on a self-branch |

## Verification
The assertions assume the host changes `loadEn` only between clock edges and keeps it high while the RAM is filled. They also assume reset is held for at least one edge. The bench loads each program with `loadEn` high and releases it once. It then keeps `loadEn` low until `halt` is seen. Every program it runs ends in a self-branch within a bounded number of instructions, so the halt assertions are exercised on every run and the sequencing checks never see a load in the middle of an instruction.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  typedef enum logic [2:0] {
    S_FETCH, S_RDA, S_RDB, S_EXEC, S_HALT
  } state_t;

  typedef struct packed {
    logic       fetch;
    logic [1:0] fieldIdx;
    logic       rdA;
    logic       rdB;
    logic       exec;
  } strobe_t;

  localparam int INSTR_WORDS = 4;
  localparam int MAP_WORDS   = 3;
endpackage

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
  import sbn_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadEn,
  input  logic    haltReq,
  output strobe_t stb,
  output logic    halt
);
  state_t state;
  logic [1:0] fieldCnt;

  always_ff @(posedge clk) begin
    if (!rstN || loadEn) begin
      state    <= S_FETCH;
      fieldCnt <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          fieldCnt <= fieldCnt + 2'd1;
          if (fieldCnt == 2'd3) state <= S_RDA;
        end
        S_RDA:   state <= S_RDB;
        S_RDB:   state <= S_EXEC;
        S_EXEC:  state <= haltReq ? S_HALT : S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.fetch    = (state == S_FETCH);
    stb.fieldIdx = fieldCnt;
    stb.rdA      = (state == S_RDA);
    stb.rdB      = (state == S_RDB);
    stb.exec     = (state == S_EXEC);
  end

  assign halt = (state == S_HALT);
endmodule

// File: rtl/sbn_dpath.sv
module sbn_dpath
  import sbn_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int START  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] peekData,
  output logic              haltReq,
  output logic [ADDR_W-1:0] pcCur
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PC_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ST_ADDR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ACC_ADDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PC_START = ADDR_W'(START);
  localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(INSTR_WORDS);

  logic [DATA_W-1:0] ram [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] fld [INSTR_WORDS];
  logic [DATA_W-1:0] opA, opB, acc;
  logic              flagNeg, flagZero;

  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] rdWord, diff;
  logic              diffNeg, diffZero;

  function automatic logic [DATA_W-1:0] mapRead(input logic [ADDR_W-1:0] a);
    if (a == PC_ADDR)       return DATA_W'(pc);
    else if (a == ST_ADDR)  return {{(DATA_W-2){1'b0}}, flagZero, flagNeg};
    else if (a == ACC_ADDR) return acc;
    else                    return ram[a];
  endfunction

  always_comb begin
    if (stb.fetch)    memAddr = pc + ADDR_W'(stb.fieldIdx);
    else if (stb.rdA) memAddr = fld[0];
    else if (stb.rdB) memAddr = fld[1];
    else              memAddr = fld[2];
  end

  assign rdWord   = mapRead(memAddr);
  assign peekData = mapRead(loadAddr);
  assign diff     = opA - opB;
  assign diffNeg  = diff[DATA_W-1];
  assign diffZero = (diff == '0);
  assign haltReq  = stb.exec && (fld[2] != PC_ADDR) && diffNeg && (fld[3] == pc);
  assign pcCur    = pc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= PC_START;
      opA      <= '0;
      opB      <= '0;
      acc      <= '0;
      flagNeg  <= 1'b0;
      flagZero <= 1'b0;
      for (int i = 0; i < INSTR_WORDS; i++) fld[i] <= '0;
    end else if (loadEn) begin
      pc <= PC_START;
    end else begin
      if (stb.fetch) fld[stb.fieldIdx] <= rdWord[ADDR_W-1:0];
      if (stb.rdA)   opA <= rdWord;
      if (stb.rdB)   opB <= rdWord;
      if (stb.exec) begin
        flagNeg  <= diffNeg;
        flagZero <= diffZero;
        if (fld[2] == ACC_ADDR) acc <= diff;
        if (fld[2] == PC_ADDR)  pc <= diff[ADDR_W-1:0];
        else if (haltReq)       pc <= pc;
        else if (diffNeg)       pc <= fld[3];
        else                    pc <= pc + PC_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn)
      ram[loadAddr] <= loadData;
    else if (stb.exec && fld[2] >= ADDR_W'(MAP_WORDS))
      ram[fld[2]] <= diff;
  end
endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int START  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] peekData,
  output logic              halt
);
  strobe_t           stb;
  logic              haltReq;
  logic [ADDR_W-1:0] pcCur;

  sbn_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn),
    .haltReq(haltReq), .stb(stb), .halt(halt)
  );

  sbn_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .START(START)) i_dpath (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .stb(stb), .peekData(peekData),
    .haltReq(haltReq), .pcCur(pcCur)
  );
endmodule

// File: rtl/sbn_checker.sv
module sbn_checker
  import sbn_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int START  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic              halt,
  input strobe_t           stb,
  input logic              haltReq,
  input logic [ADDR_W-1:0] pcCur
);
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (halt && !loadEn) |=> halt);

  assert_halt_pc_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (halt && !loadEn) |=> $stable(pcCur));

  assert_load_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (pcCur == ADDR_W'(START)) && !halt);

  assert_one_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.fetch, stb.rdA, stb.rdB, stb.exec}));

  assert_exec_then_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && !haltReq && !loadEn) |=> (stb.fetch && stb.fieldIdx == 2'd0));

  assert_exec_to_halt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && haltReq && !loadEn) |=> halt);
endmodule

bind sbn_core sbn_checker #(.ADDR_W(ADDR_W), .START(START)) i_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .halt(halt),
  .stb(stb), .haltReq(haltReq), .pcCur(pcCur)
);

// File: tb/test_sbn_core.sv
module test_sbn_core;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int ST = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b1;
  logic [AW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic [DW-1:0] peekData;
  logic          halt;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  logic [DW-1:0] mdl [256];
  logic [AW-1:0] mPc;
  logic          mNeg, mZero;
  logic [DW-1:0] mAcc;

  always #10 clk = ~clk;

  sbn_core #(.DATA_W(DW), .ADDR_W(AW), .START(ST)) i_sbn_core (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .peekData(peekData), .halt(halt)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mRead(input logic [AW-1:0] a);
    if (a == 0)      return DW'(mPc);
    else if (a == 1) return {30'b0, mZero, mNeg};
    else if (a == 2) return mAcc;
    else             return mdl[a];
  endfunction

  task automatic put(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    loadEn   = 1'b1;
    loadAddr = AW'(a);
    loadData = v;
    if (a >= 3) mdl[a] = v;
  endtask

  task automatic putInstr(input int at, input int a, input int b, input int c, input int d);
    put(at, DW'(a)); put(at + 1, DW'(b)); put(at + 2, DW'(c)); put(at + 3, DW'(d));
  endtask

  task automatic peek(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    loadAddr = AW'(a);
    #1 v = peekData;
  endtask

  // instruction-level model; returns number of instructions up to and including the halt
  task automatic runModel(output int n);
    logic [AW-1:0] fa, fb, fc, fd;
    logic [DW-1:0] d;
    bit stopped = 0;
    n = 0;
    mPc = AW'(ST);
    while (!stopped && n < 2000) begin
      fa = mRead(mPc)[AW-1:0];
      fb = mRead(mPc + 1)[AW-1:0];
      fc = mRead(mPc + 2)[AW-1:0];
      fd = mRead(mPc + 3)[AW-1:0];
      d  = mRead(fa) - mRead(fb);
      n++;
      if (fc == 2) mAcc = d;
      else if (fc >= 3) mdl[fc] = d;
      mNeg  = d[DW-1];
      mZero = (d == 0);
      if (fc == 0) mPc = d[AW-1:0];
      else if (d[DW-1] && fd == mPc) stopped = 1;
      else if (d[DW-1]) mPc = fd;
      else mPc = mPc + AW'(4);
    end
    if (!stopped) begin
      checks++; fails++;
      $display("FAIL R6 actual=no halt expected=halt in model");
    end
  endtask

  // release the core, compare halt every cycle, then compare the whole mapped memory
  task automatic runAndCompare();
    int n;
    logic [DW-1:0] v;
    runModel(n);
    @(negedge clk);
    loadEn = 1'b0;
    for (int c = 1; c <= 7 * n + 2; c++) begin
      @(negedge clk);
      check("R7 halt timing", DW'(halt), DW'(c >= 7 * n));
    end
    for (int a = 0; a < 256; a++) begin
      peek(a, v);
      check("R1 memory image", v, mRead(AW'(a)));
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    mAcc = '0; mNeg = 0; mZero = 0; mPc = AW'(ST);
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    peek(0, v); check("R11 pc", v, DW'(ST));
    peek(1, v); check("R11 status", v, '0);
    peek(2, v); check("R11 acc", v, '0);
    check("R11 halt", DW'(halt), '0);
    for (int i = 3; i < 256; i++) put(i, '0);

    // program 1: subtract, clear, copy, branch, halt
    put(100, 10); put(101, 3); put(103, 55); put(104, 0); put(106, 99);
    putInstr(4, 100, 101, 102, 8);
    putInstr(8, 103, 103, 103, 12);
    putInstr(12, 100, 104, 2, 16);
    putInstr(16, 101, 100, 105, 24);
    putInstr(20, 100, 104, 106, 20);
    putInstr(24, 104, 101, 107, 24);
    runAndCompare();
    peek(102, v); check("R1 difference", v, 7);
    peek(103, v); check("R10 self clear", v, 0);
    peek(2, v);   check("R10 copy to acc", v, 10);
    peek(105, v); check("R1 negative result", v, -7);
    peek(106, v); check("R2 skipped by branch", v, 99);
    peek(107, v); check("R6 halting write", v, -3);
    peek(0, v);   check("R6 pc at halt", v, 24);
    check("R6 halt high", DW'(halt), 1);

    // program 2: jump by pc write, status and pc reads
    put(0, 999);
    peek(0, v); check("R8 pc held during load", v, DW'(ST));
    check("R8 halt low during load", DW'(halt), 0);
    put(110, 20); put(111, 77);
    putInstr(4, 110, 104, 0, 4);
    putInstr(8, 100, 104, 111, 12);
    putInstr(20, 104, 104, 1, 24);
    putInstr(24, 1, 104, 108, 28);
    putInstr(28, 0, 104, 109, 32);
    putInstr(32, 100, 104, 2, 36);
    putInstr(36, 2, 101, 112, 40);
    putInstr(40, 104, 101, 113, 40);
    runAndCompare();
    peek(111, v); check("R4 jumped over", v, 77);
    peek(108, v); check("R5 zero flag read", v, 2);
    peek(109, v); check("R3 pc read", v, 28);
    peek(112, v); check("R3 acc read", v, 7);
    peek(1, v);   check("R5 status after halt", v, 1);
    peek(0, v);   check("R6 pc at halt", v, 40);

    // program 3: countdown loop
    put(120, 5); put(121, 1);
    putInstr(4, 120, 121, 120, 8);
    putInstr(8, 104, 120, 122, 4);
    putInstr(12, 104, 121, 123, 12);
    runAndCompare();
    peek(120, v); check("R2 loop count", v, 0);
    peek(123, v); check("R6 halting write", v, -1);
    check("R9 peek follows addr", peekData, 32'hFFFF_FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule